// File: doc/BRIEF.md
# Speculative Store Buffer

This block keeps the data of stores that have executed but not yet retired, so that no store on a wrong path ever changes memory. Each slot keeps a valid bit, a speculative bit, a sequence number, a word address and a data word. The two bits together give three named slot states: FREE (valid 0, speculative 0), SPEC (valid 1, speculative 1) and HELD (valid 1, speculative 0). The transitions are ALLOC (FREE to SPEC on an accepted execute), COMMIT (SPEC to HELD when retirement names the slot's sequence number), ABORT (SPEC to FREE when a squash names it) and DRAIN (HELD to FREE when the cache accepts the slot's write).

A load presents its address, its own sequence number and the word read from the L1 data cache. The buffer answers in the same cycle. If a live slot holds the same address and belongs to an older store, the buffer reports a hit and returns that slot's word in place of the cache word. When several such slots exist, the youngest of them wins. Age is judged by modular comparison of sequence numbers, so the comparison stays correct when the counter wraps.

Retired slots go to the cache through a ready/valid port, oldest first and one per cycle. When every slot is in use, execute is stalled.

Top module: `ssb_top`

## Requirements
- R1: After reset, every slot is FREE: `ex_ready` is 1, `dr_valid` is 0 and `ld_hit` is 0.
- R2: When `ex_valid` and `ex_ready` are both high on a clock edge, one FREE slot takes `ex_seq`, `ex_addr` and `ex_data` and enters SPEC (ALLOC). Loads see the slot from the next cycle on.
- R3: `ex_ready` is low exactly when all DEPTH slots are SPEC or HELD. An `ex_valid` pulse while `ex_ready` is low stores nothing.
- R4: `cm_valid` with a `cm_seq` that equals a SPEC slot's sequence number moves that slot to HELD (COMMIT). The slot can drain from the next cycle, and loads still see it until it drains.
- R5: `ab_valid` with an `ab_seq` that equals a SPEC slot's sequence number frees that slot (ABORT). Loads no longer see it. A commit or abort that matches no SPEC slot, including one that names a HELD slot, has no effect.
- R6: With `ld_valid` high, `ld_hit` is 1 in the same cycle if some SPEC or HELD slot has an address equal to `ld_addr` and a store older than the load. In that case `ld_data` is that slot's word. Otherwise `ld_hit` is 0 and `ld_data` equals `ld_cache_data`.
- R7: Among several matching older slots, the youngest supplies `ld_data`. Slots at the load's own sequence number or younger are ignored.
- R8: Store sequence number s is older than load sequence number l when (l - s) mod 2^SW is nonzero and below 2^(SW-1). This holds across counter wraparound.
- R9: `dr_valid` offers the HELD slot with the oldest sequence number and keeps `dr_addr` and `dr_data` steady while `dr_ready` is low. A handshake frees that slot (DRAIN), and at most one slot drains per cycle.
- R10: A SPEC slot is never offered on the drain port. With no HELD slot, `dr_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ex_valid | input | 1 | Store execute request |
| ex_ready | output | 1 | A free slot exists |
| ex_seq | input | SW | Sequence number of the executing store |
| ex_addr | input | AW | Word address of the store |
| ex_data | input | DW | Store data |
| cm_valid | input | 1 | Store commit strobe |
| cm_seq | input | SW | Sequence number being committed |
| ab_valid | input | 1 | Store abort strobe |
| ab_seq | input | SW | Sequence number being aborted |
| ld_valid | input | 1 | Load lookup request |
| ld_seq | input | SW | Sequence number of the load |
| ld_addr | input | AW | Word address of the load |
| ld_cache_data | input | DW | Word returned by the data cache |
| ld_hit | output | 1 | Buffer supplies the load data |
| ld_data | output | DW | Data returned to the load |
| dr_valid | output | 1 | A retired slot is offered to the cache |
| dr_ready | input | 1 | Cache accepts the offered write |
| dr_addr | output | AW | Address of the offered write |
| dr_data | output | DW | Data of the offered write |

## Verification
The assertions rely on a few properties of the inputs. Sequence numbers of live stores are distinct and lie within half the sequence range of one another. Commits arrive in program order, and no commit and abort name the same store in one cycle. In-order commit is what keeps the offered drain entry unchanged during backpressure, because a newly retired store is never older than one already waiting. The stimulus allocates four consecutive sequence numbers per round, commits them in ascending order and applies commit and abort in separate cycles. Each new round moves the base by seven, so the counter wraps many times while the live stores stay within a window of four.

// File: rtl/ssb_pkg.sv
package ssb_pkg;

    typedef enum logic [1:0] {
        SLOT_FREE = 2'b00,
        SLOT_HELD = 2'b10,
        SLOT_SPEC = 2'b11
    } slot_state_e;

    // a older than b in a modular space of w bits (w <= 16)
    function automatic logic seq_older(input logic [15:0] a, input logic [15:0] b, input int w);
        logic [15:0] d;
        d = (b - a) & ((16'd1 << w) - 16'd1);
        return (d != 16'd0) && !d[w-1];
    endfunction

endpackage

// File: rtl/ssb_entry.sv
module ssb_entry
    import ssb_pkg::*;
#(
    parameter int AW = 8,
    parameter int DW = 16,
    parameter int SW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          alloc,
    input  logic [SW-1:0] ex_seq,
    input  logic [AW-1:0] ex_addr,
    input  logic [DW-1:0] ex_data,
    input  logic          cm_valid,
    input  logic [SW-1:0] cm_seq,
    input  logic          ab_valid,
    input  logic [SW-1:0] ab_seq,
    input  logic          drain,
    output logic          valid_o,
    output logic          spec_o,
    output logic [SW-1:0] seq_o,
    output logic [AW-1:0] addr_o,
    output logic [DW-1:0] data_o
);

    slot_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SLOT_FREE: if (alloc) state_d = SLOT_SPEC;
            SLOT_SPEC: begin
                if (ab_valid && ab_seq == seq_o)      state_d = SLOT_FREE;
                else if (cm_valid && cm_seq == seq_o) state_d = SLOT_HELD;
            end
            SLOT_HELD: if (drain) state_d = SLOT_FREE;
            default:   state_d = SLOT_FREE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= SLOT_FREE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (alloc && state_q == SLOT_FREE) begin
            seq_o  <= ex_seq;
            addr_o <= ex_addr;
            data_o <= ex_data;
        end
    end

    always_comb begin
        valid_o = state_q[1];
        spec_o  = state_q[0];
    end

endmodule

// File: rtl/ssb_pick.sv
module ssb_pick
    import ssb_pkg::*;
#(
    parameter int DEPTH = 4,
    parameter int AW    = 8,
    parameter int SW    = 5,
    parameter int IW    = $clog2(DEPTH)
) (
    input  logic [DEPTH-1:0]         valid_vec,
    input  logic [DEPTH-1:0]         spec_vec,
    input  logic [DEPTH-1:0][SW-1:0] seq_arr,
    input  logic [DEPTH-1:0][AW-1:0] addr_arr,
    input  logic                     ld_valid,
    input  logic [SW-1:0]            ld_seq,
    input  logic [AW-1:0]            ld_addr,
    output logic [DEPTH-1:0]         free_oh,
    output logic                     has_free,
    output logic                     dr_found,
    output logic [IW-1:0]            dr_idx,
    output logic                     ld_found,
    output logic [IW-1:0]            ld_idx
);

    logic [SW-1:0] dr_best;
    logic [SW-1:0] ld_best;

    // lowest-index free slot
    always_comb begin
        free_oh  = '0;
        has_free = 1'b0;
        for (int i = 0; i < DEPTH; i++) begin
            if (!valid_vec[i] && !has_free) begin
                free_oh[i] = 1'b1;
                has_free   = 1'b1;
            end
        end
    end

    // oldest retired slot
    always_comb begin
        dr_found = 1'b0;
        dr_idx   = '0;
        dr_best  = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (valid_vec[i] && !spec_vec[i] &&
                (!dr_found || seq_older(16'(seq_arr[i]), 16'(dr_best), SW))) begin
                dr_found = 1'b1;
                dr_idx   = IW'(i);
                dr_best  = seq_arr[i];
            end
        end
    end

    // youngest matching slot older than the load
    always_comb begin
        ld_found = 1'b0;
        ld_idx   = '0;
        ld_best  = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (ld_valid && valid_vec[i] && addr_arr[i] == ld_addr &&
                seq_older(16'(seq_arr[i]), 16'(ld_seq), SW) &&
                (!ld_found || seq_older(16'(ld_best), 16'(seq_arr[i]), SW))) begin
                ld_found = 1'b1;
                ld_idx   = IW'(i);
                ld_best  = seq_arr[i];
            end
        end
    end

endmodule

// File: rtl/ssb_top.sv
module ssb_top #(
    parameter int DEPTH = 4,
    parameter int AW    = 8,
    parameter int DW    = 16,
    parameter int SW    = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ex_valid,
    output logic          ex_ready,
    input  logic [SW-1:0] ex_seq,
    input  logic [AW-1:0] ex_addr,
    input  logic [DW-1:0] ex_data,
    input  logic          cm_valid,
    input  logic [SW-1:0] cm_seq,
    input  logic          ab_valid,
    input  logic [SW-1:0] ab_seq,
    input  logic          ld_valid,
    input  logic [SW-1:0] ld_seq,
    input  logic [AW-1:0] ld_addr,
    input  logic [DW-1:0] ld_cache_data,
    output logic          ld_hit,
    output logic [DW-1:0] ld_data,
    output logic          dr_valid,
    input  logic          dr_ready,
    output logic [AW-1:0] dr_addr,
    output logic [DW-1:0] dr_data
);

    localparam int IW = $clog2(DEPTH);

    logic [DEPTH-1:0]         valid_vec;
    logic [DEPTH-1:0]         spec_vec;
    logic [DEPTH-1:0][SW-1:0] seq_arr;
    logic [DEPTH-1:0][AW-1:0] addr_arr;
    logic [DEPTH-1:0][DW-1:0] data_arr;
    logic [DEPTH-1:0]         free_oh;
    logic                     has_free;
    logic                     dr_found;
    logic [IW-1:0]            dr_idx;
    logic                     ld_found;
    logic [IW-1:0]            ld_idx;

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        ssb_entry #(.AW(AW), .DW(DW), .SW(SW)) u_entry (
            .clk      (clk),
            .rst_n    (rst_n),
            .alloc    (ex_valid && has_free && free_oh[g]),
            .ex_seq   (ex_seq),
            .ex_addr  (ex_addr),
            .ex_data  (ex_data),
            .cm_valid (cm_valid),
            .cm_seq   (cm_seq),
            .ab_valid (ab_valid),
            .ab_seq   (ab_seq),
            .drain    (dr_found && dr_ready && dr_idx == IW'(g)),
            .valid_o  (valid_vec[g]),
            .spec_o   (spec_vec[g]),
            .seq_o    (seq_arr[g]),
            .addr_o   (addr_arr[g]),
            .data_o   (data_arr[g])
        );
    end

    ssb_pick #(.DEPTH(DEPTH), .AW(AW), .SW(SW), .IW(IW)) u_pick (
        .valid_vec (valid_vec),
        .spec_vec  (spec_vec),
        .seq_arr   (seq_arr),
        .addr_arr  (addr_arr),
        .ld_valid  (ld_valid),
        .ld_seq    (ld_seq),
        .ld_addr   (ld_addr),
        .free_oh   (free_oh),
        .has_free  (has_free),
        .dr_found  (dr_found),
        .dr_idx    (dr_idx),
        .ld_found  (ld_found),
        .ld_idx    (ld_idx)
    );

    always_comb begin
        ex_ready = has_free;
        ld_hit   = ld_found;
        ld_data  = ld_found ? data_arr[ld_idx] : ld_cache_data;
        dr_valid = dr_found;
        dr_addr  = addr_arr[dr_idx];
        dr_data  = data_arr[dr_idx];
    end

endmodule

// File: rtl/ssb_chk.sv
module ssb_chk #(
    parameter int DEPTH = 4,
    parameter int AW    = 8,
    parameter int DW    = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ex_valid,
    input logic             ex_ready,
    input logic             cm_valid,
    input logic             ab_valid,
    input logic             ld_hit,
    input logic             dr_valid,
    input logic             dr_ready,
    input logic [AW-1:0]    dr_addr,
    input logic [DW-1:0]    dr_data,
    input logic [DEPTH-1:0] valid_vec,
    input logic [DEPTH-1:0] spec_vec
);

    AST_RESET_EMPTY: assert property (@(posedge clk) !rst_n |=> valid_vec == '0); // R1

    AST_ALLOC_SPEC: assert property (@(posedge clk) disable iff (!rst_n)
        ex_valid && ex_ready && !cm_valid && !ab_valid
        |=> $countones(spec_vec) == $past($countones(spec_vec)) + 1); // R2

    AST_STALL_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        !ex_ready |-> $countones(valid_vec) == DEPTH); // R3

    AST_HIT_NEEDS_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        ld_hit |-> valid_vec != '0); // R6

    AST_DRAIN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        dr_valid && !dr_ready |=> dr_valid && $stable(dr_addr) && $stable(dr_data)); // R9

    AST_DRAIN_FREES: assert property (@(posedge clk) disable iff (!rst_n)
        dr_valid && dr_ready && !(ex_valid && ex_ready) && !ab_valid
        |=> $countones(valid_vec) == $past($countones(valid_vec)) - 1); // R9

    AST_NO_SPEC_DRAIN: assert property (@(posedge clk) disable iff (!rst_n)
        dr_valid |-> (valid_vec & ~spec_vec) != '0); // R10

endmodule

bind ssb_top ssb_chk #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ex_valid  (ex_valid),
    .ex_ready  (ex_ready),
    .cm_valid  (cm_valid),
    .ab_valid  (ab_valid),
    .ld_hit    (ld_hit),
    .dr_valid  (dr_valid),
    .dr_ready  (dr_ready),
    .dr_addr   (dr_addr),
    .dr_data   (dr_data),
    .valid_vec (valid_vec),
    .spec_vec  (spec_vec)
);

// File: tb/sim_ssb_top.sv
`timescale 1ns/1ps
module sim_ssb_top;

    localparam int DEPTH = 4;
    localparam int AW    = 8;
    localparam int DW    = 16;
    localparam int SW    = 5;
    localparam int MS    = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ex_valid = 1'b0, ex_ready;
    logic [SW-1:0] ex_seq = '0;
    logic [AW-1:0] ex_addr = '0;
    logic [DW-1:0] ex_data = '0;
    logic          cm_valid = 1'b0, ab_valid = 1'b0, ld_valid = 1'b0, dr_ready = 1'b0;
    logic [SW-1:0] cm_seq = '0, ab_seq = '0, ld_seq = '0;
    logic [AW-1:0] ld_addr = '0;
    logic [DW-1:0] ld_cache_data = '0;
    logic          ld_hit, dr_valid;
    logic [DW-1:0] ld_data, dr_data;
    logic [AW-1:0] dr_addr;

    int checks = 0, errors = 0;
    bit done = 0;

    bit mv [MS];
    bit ms [MS];
    int mseq [MS];
    int maddr [MS];
    int mdata [MS];

    always #4 clk = ~clk;

    ssb_top #(.DEPTH(DEPTH), .AW(AW), .DW(DW), .SW(SW)) u0 (.*);

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic bit older(input int s, input int l);
        int d;
        d = (l - s) & 31;
        return d != 0 && d < 16;
    endfunction

    function automatic int live_count();
        int n = 0;
        for (int i = 0; i < MS; i++) if (mv[i]) n++;
        return n;
    endfunction

    task automatic do_exec(input int s, input int a, input int d);
        int full;
        @(negedge clk);
        full = (live_count() >= DEPTH);
        check(ex_ready == !full, "R3", int'(ex_ready), int'(!full));
        ex_valid = 1; ex_seq = SW'(s); ex_addr = AW'(a); ex_data = DW'(d);
        @(negedge clk);
        ex_valid = 0;
        if (!full) begin
            for (int i = 0; i < MS; i++) begin
                if (!mv[i]) begin
                    mv[i] = 1; ms[i] = 1; mseq[i] = s & 31; maddr[i] = a; mdata[i] = d;
                    break;
                end
            end
        end
    endtask

    task automatic do_commit(input int s);
        @(negedge clk);
        cm_valid = 1; cm_seq = SW'(s);
        @(negedge clk);
        cm_valid = 0;
        for (int i = 0; i < MS; i++) if (mv[i] && ms[i] && mseq[i] == (s & 31)) ms[i] = 0;
    endtask

    task automatic do_abort(input int s);
        @(negedge clk);
        ab_valid = 1; ab_seq = SW'(s);
        @(negedge clk);
        ab_valid = 0;
        for (int i = 0; i < MS; i++) if (mv[i] && ms[i] && mseq[i] == (s & 31)) mv[i] = 0;
    endtask

    task automatic probe(input int l, input int a);
        int best, cache;
        best = -1;
        cache = 16'h5A00 | a;
        for (int i = 0; i < MS; i++)
            if (mv[i] && maddr[i] == a && older(mseq[i], l & 31) &&
                (best < 0 || older(mseq[best], mseq[i]))) best = i;
        @(negedge clk);
        ld_valid = 1; ld_seq = SW'(l); ld_addr = AW'(a); ld_cache_data = DW'(cache);
        #1;
        check(ld_hit == (best >= 0), "R6 hit", int'(ld_hit), int'(best >= 0));
        check(int'(ld_data) == (best >= 0 ? mdata[best] : cache), "R7 R8 data",
              int'(ld_data), best >= 0 ? mdata[best] : cache);
        ld_valid = 0;
    endtask

    task automatic drain_one(output bit got);
        int o;
        logic [AW-1:0] a0;
        logic [DW-1:0] d0;
        o = -1;
        for (int i = 0; i < MS; i++)
            if (mv[i] && !ms[i] && (o < 0 || older(mseq[i], mseq[o]))) o = i;
        @(negedge clk);
        check(dr_valid == (o >= 0), "R10 dr_valid", int'(dr_valid), int'(o >= 0));
        got = (o >= 0);
        if (o >= 0) begin
            check(int'(dr_addr) == maddr[o], "R9 dr_addr", int'(dr_addr), maddr[o]);
            check(int'(dr_data) == mdata[o], "R9 dr_data", int'(dr_data), mdata[o]);
            a0 = dr_addr; d0 = dr_data;
            @(negedge clk);
            check(dr_valid && dr_addr == a0 && dr_data == d0, "R9 hold", int'(dr_data), int'(d0));
            dr_ready = 1;
            @(negedge clk);
            dr_ready = 0;
            mv[o] = 0;
        end
    endtask

    task automatic sweep(input int base);
        for (int l = 0; l < 32; l++)
            for (int k = 1; k <= 3; k++) probe(l, k * 16);
        probe(base + 6, 16'h20);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        bit got;
        for (int i = 0; i < MS; i++) mv[i] = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        check(ex_ready == 1, "R1 ex_ready", int'(ex_ready), 1);
        check(dr_valid == 0, "R1 dr_valid", int'(dr_valid), 0);
        check(ld_hit == 0, "R1 ld_hit", int'(ld_hit), 0);

        for (int r = 0; r < 12; r++) begin
            int b;
            b = (r * 7) & 31;
            // R2: four stores, three sharing one address
            do_exec(b,     16'h10, 16'h1000 + r * 16);
            do_exec(b + 1, 16'h20, 16'h1001 + r * 16);
            do_exec(b + 2, 16'h10, 16'h1002 + r * 16);
            do_exec(b + 3, 16'h10, 16'h1003 + r * 16);
            // R3: buffer full, this one is dropped
            do_exec(b + 4, 16'h20, 16'hBEEF);
            sweep(b);
            drain_one(got);
            check(!got, "R10 spec only", int'(got), 0);
            do_abort(b + 2);                        // R5
            sweep(b);
            do_commit(b);                           // R4
            do_commit(b + 1);
            do_commit(b + 2);                       // R5 no match
            do_abort(b);                            // R5 held slot untouched
            sweep(b);
            got = 1;
            while (got) drain_one(got);
            do_commit(b + 3);
            got = 1;
            while (got) drain_one(got);
            @(negedge clk);
            check(ex_ready == 1, "R3 empty", int'(ex_ready), 1);
            check(live_count() == 0, "R9 model empty", live_count(), 0);
        end
        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule